// File: doc/BRIEF.md
# Feedback-Voted Triple Redundant Counter

This block is a binary up-counter held in three identical replica registers. A bitwise two-of-three majority voter combines them into the count that leaves the block. Enable, a synchronous load and reset reach every replica in the same way. Each replica also has a flag that shows when its register disagrees with the voted value.

In feedback mode, every replica computes its next state from the voted value rather than from its own register. A replica that has been corrupted therefore rejoins the other two at the next clock edge, without any reset. In plain mode, each replica advances from its own register. A diverged replica then stays wrong until the next load or reset. Plain mode exists so that the two arrangements can be compared on the same hardware.

A test port overwrites the register of any one replica at a clock edge. This models a single-event upset so that masking and recovery can be exercised.

Top module: `tmr_counter`

## Requirements
- R1: A synchronous active-high reset clears all three replicas, so the count and every mismatch flag read zero after the reset edge.
- R2: With enable high and load low, the count rises by one at each clock edge and wraps from 2^WIDTH-1 to 0.
- R3: Load takes priority over enable and places load_val into all three replicas at the edge, which also clears every mismatch flag.
- R4: With enable and load both low and no upset injected, the count holds its value.
- R5: The count is the bitwise majority of the three replicas, so a single corrupted replica never changes it.
- R6: Mismatch bit k (bit 0 belongs to replica 0) is high exactly when replica k differs from the voted count.
- R7: With fb_mode high, a single corrupted replica matches the voted count again after the next clock edge, whether or not enable is high.
- R8: With fb_mode low, a single diverged replica stays diverged, with its mismatch bit high, until a load or reset.
- R9: With inj_valid high, the replica selected by inj_sel (0, 1 or 2) takes inj_val at the edge in place of its normal update. inj_sel equal to 3 selects no replica and changes nothing.
- R10: If two replicas hold the same wrong value, the vote follows them, and in feedback mode that value spreads to the third replica at the next edge.
- R11: The vote is taken per bit, so distinct bits corrupted in two different replicas are each outvoted and the count stays correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all replicas |
| rst | input | 1 | Synchronous active-high reset |
| fb_mode | input | 1 | 1: replicas advance from the voted state; 0: each replica advances from its own register |
| en | input | 1 | Count enable |
| load | input | 1 | Synchronous load, takes priority over en |
| load_val | input | WIDTH | Value taken on load |
| inj_valid | input | 1 | Upset injection strobe |
| inj_sel | input | 2 | Replica to overwrite (3 selects none) |
| inj_val | input | WIDTH | Value written into the selected replica |
| count | output | WIDTH | Voted count |
| mismatch | output | 3 | Per-replica disagreement with the voted count |

## Verification
Several behaviours are checked by assertions on every cycle:
- the reset result;
- the masking of a single disagreeing replica, which must leave the count advancing correctly;
- the repair at the edge after an upset in feedback mode;
- the persistence of a lone divergence in plain mode;
- the repair performed by a load;
- the rule that any two agreeing replicas win the vote.

Other behaviours can only be shown by the bench's scenarios. These are the full wrap sweep from every load value, the sweep of every upset value into every replica under both modes, the defeat of the vote by two equal upsets and its spread in feedback mode, and the per-bit outvoting of distinct corrupted bits.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned N_REP = 3;
  localparam int unsigned SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_NONE = 2'd3;

  typedef enum logic {
    MODE_PLAIN    = 1'b0,
    MODE_FEEDBACK = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/tmr_replica.sv
module tmr_replica #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] base,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             inj_hit,
  input  logic [WIDTH-1:0] inj_val,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] nxt;

  // load wins over count enable (R3)
  always_comb begin
    if (load)    nxt = load_val;
    else if (en) nxt = base + WIDTH'(1);
    else         nxt = base;
  end

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (inj_hit) q <= inj_val;
    else              q <= nxt;
  end

  // R9: an injected value lands in this replica
  a_r9_inject_lands: assert property (@(posedge clk) disable iff (rst)
    inj_hit |=> q == $past(inj_val));
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  output logic [WIDTH-1:0] v,
  output logic [2:0]       mism
);
  for (genvar i = 0; i < int'(WIDTH); i++) begin : g_bit
    assign v[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
  end

  assign mism[0] = (a != v);
  assign mism[1] = (b != v);
  assign mism[2] = (c != v);

  // R5: any two agreeing replicas decide the vote
  always_comb begin
    if (a == b) a_r5_pair_ab: assert (v == a);
    if (a == c) a_r5_pair_ac: assert (v == a);
    if (b == c) a_r5_pair_bc: assert (v == b);
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fb_mode,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             inj_valid,
  input  logic [SEL_W-1:0] inj_sel,
  input  logic [WIDTH-1:0] inj_val,
  output logic [WIDTH-1:0] count,
  output logic [N_REP-1:0] mismatch
);
  logic [WIDTH-1:0] rep_q [N_REP];
  logic [WIDTH-1:0] voted;
  tmr_mode_e        mode;

  assign mode = tmr_mode_e'(fb_mode);

  for (genvar k = 0; k < int'(N_REP); k++) begin : g_rep
    logic [WIDTH-1:0] base_k;
    logic             hit_k;

    // feedback mode closes the loop through the voter
    assign base_k = (mode == MODE_FEEDBACK) ? voted : rep_q[k];
    assign hit_k  = inj_valid && (inj_sel == SEL_W'(k));

    tmr_replica #(.WIDTH(WIDTH)) rep_i (
      .clk      (clk),
      .rst      (rst),
      .base     (base_k),
      .en       (en),
      .load     (load),
      .load_val (load_val),
      .inj_hit  (hit_k),
      .inj_val  (inj_val),
      .q        (rep_q[k])
    );
  end

  tmr_voter #(.WIDTH(WIDTH)) vote_i (
    .a    (rep_q[0]),
    .b    (rep_q[1]),
    .c    (rep_q[2]),
    .v    (voted),
    .mism (mismatch)
  );

  assign count = voted;

  // R1: reset result
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (count == '0) && (mismatch == '0));

  // R3: load repairs all replicas and sets the count
  a_r3_load_sets: assert property (@(posedge clk) disable iff (rst)
    (load && !inj_valid) |=> (mismatch == '0) && (count == $past(load_val)));

  // R5, R2, R4: agreement now means the count advances correctly next edge
  a_r5_masked_step: assert property (@(posedge clk) disable iff (rst)
    (mismatch == '0) |=>
      count == ($past(load) ? $past(load_val)
              : ($past(en) ? $past(count) + WIDTH'(1) : $past(count))));

  // R7: feedback repair one edge after a single upset
  a_r7_repair: assert property (@(posedge clk) disable iff (rst)
    ((mismatch == '0) && fb_mode && inj_valid && (inj_sel != SEL_NONE))
      ##1 (fb_mode && !inj_valid) |=> (mismatch == '0));

  // R8: a lone divergence persists in plain mode
  a_r8_persist: assert property (@(posedge clk) disable iff (rst)
    (!fb_mode && ($countones(mismatch) == 1) && !load && !inj_valid)
      |=> (mismatch == $past(mismatch)));
endmodule

// File: tb/tmr_counter_tb_top.sv
module tmr_counter_tb_top;
  localparam int unsigned W = 4;
  localparam int unsigned M = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fb_mode = 1'b1;
  logic         en = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] load_val = '0;
  logic         inj_valid = 1'b0;
  logic [1:0]   inj_sel = 2'd3;
  logic [W-1:0] inj_val = '0;
  logic [W-1:0] count;
  logic [2:0]   mismatch;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  tmr_counter #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .fb_mode(fb_mode), .en(en), .load(load),
    .load_val(load_val), .inj_valid(inj_valid), .inj_sel(inj_sel),
    .inj_val(inj_val), .count(count), .mismatch(mismatch)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int v);
    load = 1'b1; load_val = W'(v); en = 1'b0; inj_valid = 1'b0;
    tick();
    load = 1'b0;
  endtask

  task automatic inject(input int sel, input int v);
    inj_valid = 1'b1; inj_sel = 2'(sel); inj_val = W'(v);
    tick();
    inj_valid = 1'b0; inj_sel = 2'd3;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    chk("R1 reset count", int'(count), 0);
    chk("R1 reset mismatch", int'(mismatch), 0);
    rst = 1'b0;

    // R3 load priority with en high, R2 increment and wrap
    for (int v = 0; v < int'(M); v++) begin
      load = 1'b1; en = 1'b1; load_val = W'(v);
      tick();
      chk("R3 load over enable", int'(count), v);
      load = 1'b0;
      for (int s = 1; s <= int'(M) + 1; s++) begin
        tick();
        chk("R2 count/wrap", int'(count), (v + s) % int'(M));
      end
    end

    // R4 hold
    en = 1'b0;
    for (int s = 0; s < 3; s++) begin
      tick();
      chk("R4 hold", int'(count), (int'(M) - 1 + int'(M) + 1) % int'(M));
    end

    // R1 mid-run reset
    do_load(9);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 mid reset", int'(count), 0);

    // R5 R6 R7 R8 sweep of upsets
    for (int md = 0; md < 2; md++) begin
      for (int k = 0; k < 3; k++) begin
        for (int v = 0; v < int'(M); v++) begin
          fb_mode = md[0];
          do_load(5);
          en = 1'b1;
          inject(k, v);
          chk("R5 masked", int'(count), 6);
          chk("R6 flag", int'(mismatch), (v != 6) ? (1 << k) : 0);
          tick();
          chk("R5 masked next", int'(count), 7);
          if (md == 1)
            chk("R7 repaired", int'(mismatch), 0);
          else
            chk("R8 persists", int'(mismatch), (v != 6) ? (1 << k) : 0);
          en = 1'b0;
          do_load(0);
          chk("R3 load clears", int'(mismatch), 0);
        end
      end
    end

    // R7 repair while idle
    fb_mode = 1'b1; do_load(10);
    inject(2, 3);
    chk("R6 idle flag", int'(mismatch), 4);
    tick();
    chk("R7 idle repair", int'(mismatch), 0);
    chk("R7 idle count", int'(count), 10);

    // R9 select 3 is no replica
    do_load(4);
    inject(3, 12);
    chk("R9 none count", int'(count), 4);
    chk("R9 none flag", int'(mismatch), 0);

    // R10 two equal upsets defeat the vote
    fb_mode = 1'b0; do_load(2);
    inject(0, 13);
    inject(1, 13);
    chk("R10 vote defeated", int'(count), 13);
    chk("R10 flag", int'(mismatch), 4);
    fb_mode = 1'b1;
    tick();
    chk("R10 spreads", int'(count), 13);
    chk("R10 spread flag", int'(mismatch), 0);

    // R11 per-bit voting
    fb_mode = 1'b0; do_load(0);
    inject(0, 1);
    inject(1, 2);
    chk("R11 bitwise count", int'(count), 0);
    chk("R11 bitwise flag", int'(mismatch), 3);
    fb_mode = 1'b1;
    tick();
    chk("R11 fb cleanup", int'(mismatch), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule